// File: doc/BRIEF.md
# Serial Command/Data Receiver for a Segment Display Controller

This block takes 8-bit words from a four-wire clocked serial link (serial clock, serial data, active-low select and a command/data flag) and turns each completed word into exactly one action for the rest of a segment display controller. All four pins are asynchronous to the system clock. They pass through two-flop synchronizers, and serial-clock rising edges are found by comparing successive synchronized samples.

Bits are shifted in most significant bit first, one per serial-clock rise, and only while select is low. When the eighth bit arrives, the command/data flag sampled at that same rise decides the word's meaning. With the flag low, the whole byte is handed on as display data. With the flag high, the upper three bits are an opcode. The opcodes cover: loading a 5-bit address, forcing every segment lit, forcing every segment dark, showing memory contents, writing an inline 4-bit nibble, and a soft reset that the downstream logic uses to blank the display and clear its address counter. Each result is a registered single-cycle pulse with a held payload. The block itself stores no display memory, so the force-on and force-off commands can never cause a write.

Top module: `segdrv_cmd_rx`

## Requirements
- R1: A word is assembled from 8 consecutive serial-clock rises while select is low, with the first bit landing in bit 7. Several words may follow one another inside a single select-low period.
- R2: If select goes high before the eighth bit, the partial word is discarded and produces no output. The next word starts with a fresh bit count.
- R3: The command/data flag is sampled only at the eighth rise of a word: 0 means display data, 1 means command. Its level at the other seven rises has no effect. A data word gives `data_vld` high for one cycle with `data_byte` equal to the word.
- R4: Command opcode 000 (bits 7:5) pulses `addr_ld` with `addr_val` equal to bits 4:0.
- R5: Opcode 001 pulses `force_on`, opcode 010 pulses `force_off`, and opcode 011 pulses `show_ram`. Bits 4:0 are don't-care for these three.
- R6: Opcode 100 pulses `nib_wr` with `nib_val` equal to bits 3:0. Bit 4 is don't-care.
- R7: Opcode 110 pulses `soft_rst`. Bits 4:0 are don't-care.
- R8: Opcodes 101 and 111 produce no output pulse and leave word framing intact for the following word.
- R9: Each completed word raises at most one of the six pulse outputs, and that pulse lasts for exactly one clock cycle.
- R10: While `rst` is high and in the cycle after it, all pulse outputs are low.
- R11: Serial-clock rises seen while select is high shift in no bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_sclk | input | 1 | Serial clock (asynchronous) |
| pin_sdat | input | 1 | Serial data, MSB first |
| pin_sel_n | input | 1 | Active-low select |
| pin_cmd | input | 1 | Command/data flag: 1 command, 0 display data |
| data_vld | output | 1 | Display-data byte pulse |
| data_byte | output | 8 | Display-data byte |
| addr_ld | output | 1 | Address-load pulse |
| addr_val | output | 5 | Address value |
| force_on | output | 1 | All-segments-on pulse |
| force_off | output | 1 | All-segments-off pulse |
| show_ram | output | 1 | Normal-display pulse |
| nib_wr | output | 1 | Inline nibble-write pulse |
| nib_val | output | 4 | Nibble to write |
| soft_rst | output | 1 | Soft-reset pulse |

## Verification
The bench drives the command/data flag to the opposite level on the first seven bits of a word, so a design that samples the flag early or late misclassifies the word. It aborts a word after three bits and then sends a full one: a design that kept the stale bit count would emit a shifted byte. It toggles the serial clock while select is high, sends two back-to-back words inside one select-low period, and sends the reserved opcodes 101 and 111 followed by a data word. A design that decodes a reserved opcode as a neighbouring command, or loses framing afterwards, shows up as an unexpected or mismatched pulse in the scoreboard.

// File: rtl/segdrv_pkg.sv
package segdrv_pkg;
  localparam int OPC_W = 3;
  typedef enum logic [OPC_W-1:0] {
    OPC_ADDR   = 3'b000,
    OPC_ALLON  = 3'b001,
    OPC_ALLOFF = 3'b010,
    OPC_SHOW   = 3'b011,
    OPC_NIB    = 3'b100,
    OPC_SRST   = 3'b110
  } opc_e;
endpackage

// File: rtl/segdrv_sync.sv
module segdrv_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= INIT;
      q    <= INIT;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/segdrv_shift.sv
module segdrv_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              sel_n_s,
  input  logic              cmd_s,
  output logic              done,
  output logic [WORD_W-1:0] word,
  output logic              is_cmd
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              sclk_d;
  logic              rise;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] sh;
  logic [WORD_W-1:0] sh_nxt;

  assign rise   = sclk_s & ~sclk_d;
  assign sh_nxt = {sh[WORD_W-2:0], sdat_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
      done   <= 1'b0;
      word   <= '0;
      is_cmd <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      done   <= 1'b0;
      if (sel_n_s) begin
        cnt <= '0;
      end else if (rise) begin
        sh <= sh_nxt;
        if (cnt == LAST) begin
          cnt    <= '0;
          done   <= 1'b1;
          word   <= sh_nxt;
          is_cmd <= cmd_s;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/segdrv_decode.sv
module segdrv_decode
  import segdrv_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int ADDR_W = 5,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [WORD_W-1:0] word,
  input  logic              is_cmd,
  output logic              data_vld,
  output logic [WORD_W-1:0] data_byte,
  output logic              addr_ld,
  output logic [ADDR_W-1:0] addr_val,
  output logic              force_on,
  output logic              force_off,
  output logic              show_ram,
  output logic              nib_wr,
  output logic [NIB_W-1:0]  nib_val,
  output logic              soft_rst
);
  logic [OPC_W-1:0] opc;
  assign opc = word[WORD_W-1 -: OPC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      data_vld  <= 1'b0;
      data_byte <= '0;
      addr_ld   <= 1'b0;
      addr_val  <= '0;
      force_on  <= 1'b0;
      force_off <= 1'b0;
      show_ram  <= 1'b0;
      nib_wr    <= 1'b0;
      nib_val   <= '0;
      soft_rst  <= 1'b0;
    end else begin
      data_vld  <= 1'b0;
      addr_ld   <= 1'b0;
      force_on  <= 1'b0;
      force_off <= 1'b0;
      show_ram  <= 1'b0;
      nib_wr    <= 1'b0;
      soft_rst  <= 1'b0;
      if (done) begin
        if (!is_cmd) begin
          data_vld  <= 1'b1;
          data_byte <= word;
        end else begin
          case (opc)
            OPC_ADDR: begin
              addr_ld  <= 1'b1;
              addr_val <= word[ADDR_W-1:0];
            end
            OPC_ALLON:  force_on  <= 1'b1;
            OPC_ALLOFF: force_off <= 1'b1;
            OPC_SHOW:   show_ram  <= 1'b1;
            OPC_NIB: begin
              nib_wr  <= 1'b1;
              nib_val <= word[NIB_W-1:0];
            end
            OPC_SRST:   soft_rst  <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/segdrv_cmd_rx.sv
module segdrv_cmd_rx #(
  parameter int WORD_W = 8,
  parameter int ADDR_W = 5,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_sclk,
  input  logic              pin_sdat,
  input  logic              pin_sel_n,
  input  logic              pin_cmd,
  output logic              data_vld,
  output logic [WORD_W-1:0] data_byte,
  output logic              addr_ld,
  output logic [ADDR_W-1:0] addr_val,
  output logic              force_on,
  output logic              force_off,
  output logic              show_ram,
  output logic              nib_wr,
  output logic [NIB_W-1:0]  nib_val,
  output logic              soft_rst
);
  localparam int NPIN = 4;

  logic [NPIN-1:0]   pins_s;
  logic              word_done;
  logic [WORD_W-1:0] word_q;
  logic              word_cmd;

  segdrv_sync #(.W(NPIN), .INIT(4'b0100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({pin_cmd, pin_sel_n, pin_sdat, pin_sclk}),
    .q   (pins_s)
  );

  segdrv_shift #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .sclk_s  (pins_s[0]),
    .sdat_s  (pins_s[1]),
    .sel_n_s (pins_s[2]),
    .cmd_s   (pins_s[3]),
    .done    (word_done),
    .word    (word_q),
    .is_cmd  (word_cmd)
  );

  segdrv_decode #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .done      (word_done),
    .word      (word_q),
    .is_cmd    (word_cmd),
    .data_vld  (data_vld),
    .data_byte (data_byte),
    .addr_ld   (addr_ld),
    .addr_val  (addr_val),
    .force_on  (force_on),
    .force_off (force_off),
    .show_ram  (show_ram),
    .nib_wr    (nib_wr),
    .nib_val   (nib_val),
    .soft_rst  (soft_rst)
  );
endmodule

// File: rtl/segdrv_cmd_chk.sv
module segdrv_cmd_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              word_done,
  input logic [WORD_W-1:0] word_q,
  input logic              word_cmd,
  input logic              data_vld,
  input logic [WORD_W-1:0] data_byte,
  input logic              addr_ld,
  input logic              force_on,
  input logic              force_off,
  input logic              show_ram,
  input logic              nib_wr,
  input logic              soft_rst
);
  logic [5:0] pulses;
  assign pulses = {data_vld, addr_ld, force_on, force_off, show_ram, nib_wr};
  logic any_p;
  assign any_p = (|pulses) | soft_rst;

  a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pulses, soft_rst}));

  a_r9_single_cycle: assert property (@(posedge clk) disable iff (rst)
    any_p |=> !any_p);

  a_r10_reset_quiet: assert property (@(posedge clk)
    rst |=> !any_p);

  a_r3_data_word: assert property (@(posedge clk) disable iff (rst)
    (word_done && !word_cmd) |=> (data_vld && data_byte == $past(word_q)));

  a_r8_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
    (word_done && word_cmd && word_q[WORD_W-1 -: 3] inside {3'b101, 3'b111}) |=> !any_p);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !word_done |=> !any_p);
endmodule

bind segdrv_cmd_rx segdrv_cmd_chk #(.WORD_W(WORD_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .word_done (word_done),
  .word_q    (word_q),
  .word_cmd  (word_cmd),
  .data_vld  (data_vld),
  .data_byte (data_byte),
  .addr_ld   (addr_ld),
  .force_on  (force_on),
  .force_off (force_off),
  .show_ram  (show_ram),
  .nib_wr    (nib_wr),
  .soft_rst  (soft_rst)
);

// File: tb/segdrv_cmd_rx_tb_top.sv
module segdrv_cmd_rx_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin_sclk = 1'b0, pin_sdat = 1'b0, pin_sel_n = 1'b1, pin_cmd = 1'b0;
  logic       data_vld, addr_ld, force_on, force_off, show_ram, nib_wr, soft_rst;
  logic [7:0] data_byte;
  logic [4:0] addr_val;
  logic [3:0] nib_val;

  always #4 clk = ~clk;

  segdrv_cmd_rx dut_i (
    .clk(clk), .rst(rst), .pin_sclk(pin_sclk), .pin_sdat(pin_sdat),
    .pin_sel_n(pin_sel_n), .pin_cmd(pin_cmd),
    .data_vld(data_vld), .data_byte(data_byte), .addr_ld(addr_ld),
    .addr_val(addr_val), .force_on(force_on), .force_off(force_off),
    .show_ram(show_ram), .nib_wr(nib_wr), .nib_val(nib_val), .soft_rst(soft_rst)
  );

  // kinds: 1 data, 2 addr, 3 on, 4 off, 5 show, 6 nibble, 7 soft reset
  int    exp_q[$];
  string tag_q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    finished = 0;

  task automatic expect_item(input int kind, input int payload, input string tag);
    exp_q.push_back(kind * 256 + payload);
    tag_q.push_back(tag);
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // one word of 8 bits; cd_last at the 8th rise, cd_other at the others
  task automatic send_bits(input logic [7:0] b, input bit cd_last, input bit cd_other);
    for (int i = 7; i >= 0; i--) begin
      pin_sdat = b[i];
      pin_cmd  = (i == 0) ? cd_last : cd_other;
      wclk(4);
      pin_sclk = 1'b1;
      wclk(4);
      pin_sclk = 1'b0;
    end
  endtask

  task automatic send_word(input logic [7:0] b, input bit cd_last, input bit cd_other);
    pin_sel_n = 1'b0;
    wclk(4);
    send_bits(b, cd_last, cd_other);
    wclk(4);
    pin_sel_n = 1'b1;
    wclk(12);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !finished) begin
      int cnt_p;
      int act;
      cnt_p = int'(data_vld) + int'(addr_ld) + int'(force_on) + int'(force_off)
            + int'(show_ram) + int'(nib_wr) + int'(soft_rst);
      if (cnt_p > 1) begin
        n_chk++; n_bad++;
        $display("FAIL R9: %0d pulses at once, expected at most 1", cnt_p);
      end else if (cnt_p == 1) begin
        act = data_vld  ? 256 + int'(data_byte) :
              addr_ld   ? 512 + int'(addr_val)  :
              force_on  ? 768                   :
              force_off ? 1024                  :
              show_ram  ? 1280                  :
              nib_wr    ? 1536 + int'(nib_val)  : 1792;
        n_chk++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R8/R9: unexpected item 0x%0h, expected none", act);
        end else begin
          int    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (e != act) begin
            n_bad++;
            $display("FAIL %s: got item 0x%0h, expected 0x%0h", t, act, e);
          end
        end
      end
    end
  end

  initial begin
    wclk(5);
    // R10: outputs quiet under reset
    n_chk++;
    if ({data_vld, addr_ld, force_on, force_off, show_ram, nib_wr, soft_rst} != 7'd0) begin
      n_bad++;
      $display("FAIL R10: pulses=%b expected 0000000",
               {data_vld, addr_ld, force_on, force_off, show_ram, nib_wr, soft_rst});
    end
    rst = 1'b0;
    wclk(5);

    expect_item(1, 8'hA5, "R1/R3 data with flag high early");
    send_word(8'hA5, 1'b0, 1'b1);
    expect_item(1, 8'h3C, "R1 data");
    send_word(8'h3C, 1'b0, 1'b0);
    expect_item(2, 5'h1B, "R4 address set");
    send_word(8'h1B, 1'b1, 1'b0);
    expect_item(2, 5'h03, "R4 address set low");
    send_word(8'h03, 1'b1, 1'b1);
    expect_item(3, 0, "R5 force on");
    send_word(8'h2F, 1'b1, 1'b0);
    expect_item(4, 0, "R5 force off");
    send_word(8'h5F, 1'b1, 1'b0);
    expect_item(5, 0, "R5 show ram");
    send_word(8'h60, 1'b1, 1'b0);
    expect_item(6, 4'hA, "R6 nibble write");
    send_word(8'h8A, 1'b1, 1'b0);
    expect_item(6, 4'hF, "R6 nibble write bit4 set");
    send_word(8'h9F, 1'b1, 1'b0);
    expect_item(7, 0, "R7 soft reset");
    send_word(8'hC7, 1'b1, 1'b0);
    expect_item(7, 0, "R7 soft reset other payload");
    send_word(8'hD0, 1'b1, 1'b0);
    // R3: flag high on seven bits but low at the eighth -> data
    expect_item(1, 8'h8A, "R3 flag low at eighth");
    send_word(8'h8A, 1'b0, 1'b1);

    // R8: reserved opcodes then data
    send_word(8'hA3, 1'b1, 1'b0);
    send_word(8'hFF, 1'b1, 1'b1);
    expect_item(1, 8'h11, "R8 framing after reserved");
    send_word(8'h11, 1'b0, 1'b0);

    // R2: aborted partial word
    pin_sel_n = 1'b0;
    wclk(4);
    for (int i = 0; i < 3; i++) begin
      pin_sdat = 1'b1; pin_cmd = 1'b1;
      wclk(4); pin_sclk = 1'b1; wclk(4); pin_sclk = 1'b0;
    end
    wclk(4);
    pin_sel_n = 1'b1;
    wclk(12);
    expect_item(1, 8'h96, "R2 word after abort");
    send_word(8'h96, 1'b0, 1'b0);

    // R11: clocks while deselected
    for (int i = 0; i < 5; i++) begin
      pin_sdat = 1'b1;
      wclk(4); pin_sclk = 1'b1; wclk(4); pin_sclk = 1'b0;
    end
    wclk(8);
    expect_item(1, 8'h42, "R11 word after deselected clocks");
    send_word(8'h42, 1'b0, 1'b0);

    // R1: two words inside one select period
    expect_item(2, 5'h15, "R1 back-to-back first");
    expect_item(1, 8'hE7, "R1 back-to-back second");
    pin_sel_n = 1'b0;
    wclk(4);
    send_bits(8'h15, 1'b1, 1'b0);
    send_bits(8'hE7, 1'b0, 1'b1);
    wclk(4);
    pin_sel_n = 1'b1;
    wclk(20);

    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R9: %0d expected items never seen, expected 0", exp_q.size());
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule